// File: doc/BRIEF.md
# Command-Driven Random Number Generator

This block is a stand-alone random number source behind a small 32-bit register bus. Software issues a command: generate, seed, or nothing. It follows the block's progress through three status flags: seeded, generating, reseeding. The finished random words are read from a bank of eight 32-bit output registers. A run fills either the lower four words (128-bit mode) or all eight (256-bit mode). Completion of a run sets a ready flag, and completion of any seeding sets a seed-done flag. Both flags are cleared by writing one to them, and both can drive a single interrupt line through per-flag enables and a global enable.

The entropy source and the conditioning stage are modelled by a 32-bit maximal-length LFSR. The LFSR advances on every busy cycle and is mixed with a free-running counter each time a seed finishes. The block keeps a running count of its output in 16-byte units. When that count reaches a programmable limit, the block starts a reseed on its own as soon as the run that crossed the limit completes. With the auto-seed parameter set, the block seeds itself straight out of reset. With it clear, the first generate command seeds the block before it generates. A read-only identification register returns a fixed code.

Top module: `rng_core`

## Requirements
- R1: A read of address 0xF0 returns 0x000046BC.
- R2: With AUTO_SEED=1, STAT (0x04) bit 31 (reseeding) is high and bit 9 (seeded) low from reset. Bit 31 stays high for SEED_LEN cycles after reset release. Then bit 9 reads 1 and ISTAT (0x14) reads 0x2.
- R3: Writing 1 to CTRL (0x00) while idle and seeded, with MODE (0x08) bit 3 = 1, holds STAT bit 30 (generating) high for GEN_LEN cycles. After that, ISTAT bit 0 (ready) is set, and the words at 0x20, 0x24 … 0x3C are all nonzero and pairwise distinct.
- R4: The same command with MODE bit 3 = 0 holds bit 30 high for GEN_LEN/2 cycles. Words 0–3 (0x20–0x2C) end up nonzero and distinct, and words 4–7 (0x30–0x3C) read 0.
- R5: In the cycle after a generate command is accepted, all output words read 0.
- R6: Writing 2 to CTRL while idle holds STAT bit 31 high for SEED_LEN cycles. After that, ISTAT bit 1 (seed done) is set.
- R7: With AUTO_SEED=0, STAT reads 0 after reset. A generate command then seeds for SEED_LEN cycles, generates for the mode's run length, and leaves the block seeded with ISTAT = 0x3.
- R8: A command written while the block is busy has no effect on the phase or its length. CTRL values 0 and 3 written while idle change neither status nor output words.
- R9: Writing ISTAT clears exactly the bits written as 1 (bit 0 ready, bit 1 seed done). Bits written as 0 keep their value.
- R10: irq equals IE (0x10) bit 31 AND ((ISTAT bit 0 AND IE bit 0) OR (ISTAT bit 1 AND IE bit 1)).
- R11: Each completed run adds 1 (128-bit) or 2 (256-bit) to a unit count, and any seed completion clears the count. When the limit N in 0x60 is nonzero and the new count reaches N, reseeding (STAT bit 31) starts in the cycle the run ends. N = 0 disables this.
- R12: MODE bit 3, IE bits 31/1/0 and the limit in 0x60 (REQ_W bits) read back as written, with all other bits reading 0.
- R13: Two successive generate runs give different contents in word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies with GEN_LEN=32, SEED_LEN=12 and an 8-bit limit register. The short run lengths let exact phase durations, auto-reseed thresholds in both modes, and busy-time command writes be reached within a few hundred cycles. One copy has AUTO_SEED=1, which exposes the power-on self-seed. The other has AUTO_SEED=0, which is the only way to reach the seed-then-generate path for a generate command issued before any seed.

// File: rtl/rng_pkg.sv
package rng_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEED = 2'd1,
        PH_GEN  = 2'd2
    } phase_t;

    localparam int NWORDS = 8;
    localparam int IW     = $clog2(NWORDS);

    localparam logic [7:0] A_CMD   = 8'h00;
    localparam logic [7:0] A_STAT  = 8'h04;
    localparam logic [7:0] A_MODE  = 8'h08;
    localparam logic [7:0] A_IE    = 8'h10;
    localparam logic [7:0] A_ISTAT = 8'h14;
    localparam logic [7:0] A_LIMIT = 8'h60;
    localparam logic [7:0] A_ID    = 8'hF0;

    localparam logic [31:0] ID_CODE = 32'h0000_46BC;

    localparam logic [1:0] OP_NOP  = 2'd0;
    localparam logic [1:0] OP_GEN  = 2'd1;
    localparam logic [1:0] OP_SEED = 2'd2;

    // Galois form of x^32 + x^22 + x^2 + x + 1
    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr
    import rng_pkg::*;
#(
    parameter logic [31:0] INIT = 32'h1D87_2B41
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        mix,
    output logic [31:0] state
);
    logic [31:0] jitter;
    logic [31:0] mixed;

    assign mixed = lfsr_step(state) ^ jitter;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= INIT;
            jitter <= '0;
        end else begin
            jitter <= jitter + 32'd1;
            if (mix)
                state <= (mixed == 32'd0) ? INIT : mixed;
            else if (step)
                state <= lfsr_step(state);
        end
    end
endmodule

// File: rtl/rng_seq.sv
module rng_seq
    import rng_pkg::*;
#(
    parameter int GEN_LEN   = 1024,
    parameter int SEED_LEN  = 512,
    parameter bit AUTO_SEED = 1'b1,
    parameter int REQ_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             mode_wide,
    input  logic [REQ_W-1:0] auto_n,
    output phase_t           phase,
    output logic             seeded,
    output logic             fill_en,
    output logic [IW-1:0]    fill_idx,
    output logic             gen_done,
    output logic             seed_done,
    output logic             gen_start
);
    localparam int MAXL = (GEN_LEN > SEED_LEN) ? GEN_LEN : SEED_LEN;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] SEED_TOP   = CW'(SEED_LEN - 1);
    localparam logic [CW-1:0] WIDE_TOP   = CW'(GEN_LEN - 1);
    localparam logic [CW-1:0] NARROW_TOP = CW'(GEN_LEN / 2 - 1);

    logic [CW-1:0]    cnt;
    logic             wide_q;
    logic             pend;
    logic [REQ_W-1:0] reqs;
    logic [REQ_W:0]   sum;
    logic             accept;
    logic             reseed_due;
    logic [CW-1:0]    nwords;

    assign accept     = cmd_valid && (phase == PH_IDLE);
    assign gen_done   = (phase == PH_GEN)  && (cnt == '0);
    assign seed_done  = (phase == PH_SEED) && (cnt == '0);
    assign gen_start  = (accept && cmd_op == OP_GEN && seeded) || (seed_done && pend);
    assign nwords     = wide_q ? CW'(NWORDS) : CW'(NWORDS / 2);
    assign fill_en    = (phase == PH_GEN) && (cnt < nwords);
    assign fill_idx   = cnt[IW-1:0];
    assign sum        = {1'b0, reqs} + (wide_q ? (REQ_W+1)'(2) : (REQ_W+1)'(1));
    assign reseed_due = (auto_n != '0) && (sum >= {1'b0, auto_n});

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= AUTO_SEED ? PH_SEED : PH_IDLE;
            cnt    <= AUTO_SEED ? SEED_TOP : '0;
            seeded <= 1'b0;
            wide_q <= 1'b0;
            pend   <= 1'b0;
            reqs   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        if (cmd_op == OP_GEN) begin
                            wide_q <= mode_wide;
                            if (seeded) begin
                                phase <= PH_GEN;
                                cnt   <= mode_wide ? WIDE_TOP : NARROW_TOP;
                            end else begin
                                phase <= PH_SEED;
                                cnt   <= SEED_TOP;
                                pend  <= 1'b1;
                            end
                        end else if (cmd_op == OP_SEED) begin
                            phase <= PH_SEED;
                            cnt   <= SEED_TOP;
                        end
                    end
                end
                PH_SEED: begin
                    if (cnt == '0) begin
                        seeded <= 1'b1;
                        reqs   <= '0;
                        if (pend) begin
                            phase <= PH_GEN;
                            cnt   <= wide_q ? WIDE_TOP : NARROW_TOP;
                            pend  <= 1'b0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_GEN: begin
                    if (cnt == '0) begin
                        if (reseed_due) begin
                            phase <= PH_SEED;
                            cnt   <= SEED_TOP;
                            reqs  <= '0;
                        end else begin
                            phase <= PH_IDLE;
                            reqs  <= (auto_n == '0) ? '0 : sum[REQ_W-1:0];
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rng_core.sv
module rng_core
    import rng_pkg::*;
#(
    parameter int GEN_LEN   = 1024,
    parameter int SEED_LEN  = 512,
    parameter bit AUTO_SEED = 1'b1,
    parameter int REQ_W     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    phase_t           phase;
    logic             seeded, fill_en, gen_done, seed_done, gen_start;
    logic [IW-1:0]    fill_idx;
    logic [31:0]      lfsr_q;
    logic             mode_wide, ie_glb, ie_seed, ie_rdy;
    logic [1:0]       istat;
    logic [REQ_W-1:0] auto_n;
    logic [31:0]      words [NWORDS];
    logic             cmd_valid;
    logic [1:0]       clr_mask;
    logic             unused_wdata;

    assign cmd_valid    = bus_wr && (bus_addr == A_CMD);
    assign clr_mask     = (bus_wr && bus_addr == A_ISTAT) ? bus_wdata[1:0] : 2'b00;
    assign unused_wdata = ^bus_wdata;

    rng_seq #(
        .GEN_LEN(GEN_LEN), .SEED_LEN(SEED_LEN),
        .AUTO_SEED(AUTO_SEED), .REQ_W(REQ_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(bus_wdata[1:0]),
        .mode_wide(mode_wide), .auto_n(auto_n),
        .phase(phase), .seeded(seeded),
        .fill_en(fill_en), .fill_idx(fill_idx),
        .gen_done(gen_done), .seed_done(seed_done), .gen_start(gen_start)
    );

    rng_lfsr u_lfsr (
        .clk(clk), .rst(rst),
        .step(phase != PH_IDLE), .mix(seed_done),
        .state(lfsr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_wide <= 1'b0;
            ie_glb    <= 1'b0;
            ie_seed   <= 1'b0;
            ie_rdy    <= 1'b0;
            istat     <= 2'b00;
            auto_n    <= '0;
        end else begin
            if (bus_wr && bus_addr == A_MODE)
                mode_wide <= bus_wdata[3];
            if (bus_wr && bus_addr == A_IE) begin
                ie_glb  <= bus_wdata[31];
                ie_seed <= bus_wdata[1];
                ie_rdy  <= bus_wdata[0];
            end
            if (bus_wr && bus_addr == A_LIMIT)
                auto_n <= bus_wdata[REQ_W-1:0];
            istat <= (istat & ~clr_mask) | {seed_done, gen_done};
        end
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || gen_start)
                words[i] <= '0;
            else if (fill_en && fill_idx == IW'(i))
                words[i] <= lfsr_q;
        end
    end

    assign irq = ie_glb && ((istat[0] && ie_rdy) || (istat[1] && ie_seed));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00) begin
            bus_rdata = words[bus_addr[4:2]];
        end else begin
            unique case (bus_addr)
                A_CMD:   bus_rdata[1:0] = (phase == PH_SEED) ? OP_SEED :
                                          (phase == PH_GEN)  ? OP_GEN  : OP_NOP;
                A_STAT: begin
                    bus_rdata[31] = (phase == PH_SEED);
                    bus_rdata[30] = (phase == PH_GEN);
                    bus_rdata[9]  = seeded;
                end
                A_MODE:  bus_rdata[3] = mode_wide;
                A_IE: begin
                    bus_rdata[31] = ie_glb;
                    bus_rdata[1]  = ie_seed;
                    bus_rdata[0]  = ie_rdy;
                end
                A_ISTAT: bus_rdata[1:0] = istat;
                A_LIMIT: bus_rdata[REQ_W-1:0] = auto_n;
                A_ID:    bus_rdata = ID_CODE;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rng_core_chk.sv
module rng_core_chk
    import rng_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input phase_t      phase,
    input logic        seeded,
    input logic        gen_done,
    input logic        seed_done,
    input logic        gen_start,
    input logic [1:0]  istat,
    input logic [31:0] word0,
    input logic        irq,
    input logic        ie_glb
);
    AST_RDY_AFTER_GEN: assert property (@(posedge clk) disable iff (rst)
        gen_done |=> istat[0]);                                   // R3
    AST_WORDS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        gen_start |=> (word0 == 32'd0));                          // R5
    AST_SEED_FLAG: assert property (@(posedge clk) disable iff (rst)
        seed_done |=> (istat[1] && seeded));                      // R6
    AST_GEN_SEEDED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GEN) |-> seeded);                            // R7
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GEN && !gen_done) |=> (phase == PH_GEN));    // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie_glb && istat != 2'b00));                      // R10
endmodule

bind rng_core rng_core_chk u_chk (
    .clk(clk), .rst(rst), .phase(phase), .seeded(seeded),
    .gen_done(gen_done), .seed_done(seed_done), .gen_start(gen_start),
    .istat(istat), .word0(words[0]), .irq(irq), .ie_glb(ie_glb)
);

// File: tb/sim_rng_core.sv
`timescale 1ns/1ps
module sim_rng_core;
    localparam int GL = 32;
    localparam int SL = 12;
    localparam logic [7:0] CTRL = 8'h00, STAT = 8'h04, MODE = 8'h08, IE = 8'h10,
                           ISTAT = 8'h14, W0 = 8'h20, LIM = 8'h60, VER = 8'hF0;

    logic clk = 1'b0, rst = 1'b1, wr0 = 1'b0, wr1 = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;
    int checks = 0, fails = 0;
    logic [31:0] cur [8];
    logic [31:0] prev0;

    always #2.5 clk = ~clk;

    rng_core #(.GEN_LEN(GL), .SEED_LEN(SL), .AUTO_SEED(1'b1), .REQ_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_wr(wr0), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd0), .irq(irq0));
    rng_core #(.GEN_LEN(GL), .SEED_LEN(SL), .AUTO_SEED(1'b0), .REQ_W(8)) u1 (
        .clk(clk), .rst(rst), .bus_wr(wr1), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd1), .irq(irq1));

    function automatic bit exp_irq(logic [2:0] ie, logic [1:0] is);
        return ie[2] && ((is[0] && ie[0]) || (is[1] && ie[1]));
    endfunction

    function automatic int exp_len(bit wide);
        return wide ? GL : GL / 2;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int inst, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (inst == 0) wr0 = 1'b1; else wr1 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic rd(int inst, logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = (inst == 0) ? rd0 : rd1;
    endtask

    task automatic wait_idle(int inst);
        logic [31:0] s;
        for (int k = 0; k < 1000; k++) begin
            rd(inst, STAT, s);
            if (!s[31] && !s[30]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_rand(int inst, bit wide, output int gcyc, output bit rs_after);
        logic [31:0] s, w0, w7;
        wr(inst, MODE, {28'd0, wide, 3'd0});
        wr(inst, CTRL, 32'd1);
        rd(inst, W0, w0);
        rd(inst, W0 + 8'h1C, w7);
        chk(w0 == 0 && w7 == 0, "R5 words cleared on accept", w0 | w7, 32'd0);
        gcyc = 0;
        rd(inst, STAT, s);
        while (s[30] && gcyc < 1000) begin
            gcyc++;
            @(negedge clk);
            rd(inst, STAT, s);
        end
        rs_after = s[31];
    endtask

    task automatic check_words(int inst, bit wide, string tag);
        int n;
        n = wide ? 8 : 4;
        for (int i = 0; i < 8; i++) rd(inst, W0 + 8'(4 * i), cur[i]);
        for (int i = 0; i < 8; i++) begin
            if (i < n) chk(cur[i] != 0, tag, cur[i], 32'hFFFF_FFFF);
            else       chk(cur[i] == 0, tag, cur[i], 32'd0);
            for (int j = i + 1; j < n; j++)
                chk(cur[i] != cur[j], tag, cur[j], ~cur[i]);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] s;
        int cnt, g;
        bit rs, wide;
        logic [1:0] exp_is, clr;
        logic [2:0] ie;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: self seed out of reset
        rd(0, STAT, s);
        chk(s[31] && !s[9], "R2 reseeding at reset", s, 32'h8000_0000);
        cnt = 0;
        while (s[31] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            rd(0, STAT, s);
        end
        chk(cnt == SL, "R2 reseed length", cnt, SL);
        chk(s == 32'h200, "R2 seeded after reset", s, 32'h200);
        rd(0, ISTAT, s);
        chk(s == 32'h2, "R2 seed-done flag", s, 32'h2);
        rd(1, STAT, s);
        chk(s == 32'h0, "R7 no auto seed", s, 32'h0);
        // R1
        rd(0, VER, s); chk(s == 32'h46BC, "R1 version", s, 32'h46BC);
        rd(1, VER, s); chk(s == 32'h46BC, "R1 version u1", s, 32'h46BC);

        // R12 readback
        wr(0, MODE, 32'hFFFF_FFFF); rd(0, MODE, s); chk(s == 32'h8, "R12 mode", s, 32'h8);
        wr(0, MODE, 32'hFFFF_FFF7); rd(0, MODE, s); chk(s == 32'h0, "R12 mode clr", s, 32'h0);
        wr(0, IE, 32'hFFFF_FFFF); rd(0, IE, s); chk(s == 32'h8000_0003, "R12 ie", s, 32'h8000_0003);
        wr(0, LIM, 32'h1234_565A); rd(0, LIM, s); chk(s == 32'h5A, "R12 limit", s, 32'h5A);
        wr(0, IE, 32'h0);
        wr(0, LIM, 32'h0);
        wr(0, ISTAT, 32'h3);
        rd(0, ISTAT, s); chk(s == 32'h0, "R9 clear both", s, 32'h0);

        // R3 wide run
        run_rand(0, 1'b1, g, rs);
        chk(g == GL, "R3 wide length", g, GL);
        chk(!rs, "R11 disabled no reseed", rs, 0);
        rd(0, ISTAT, s); chk(s == 32'h1, "R3 ready flag", s, 32'h1);
        check_words(0, 1'b1, "R3 wide words");
        prev0 = cur[0];

        // R4 narrow run
        run_rand(0, 1'b0, g, rs);
        chk(g == GL / 2, "R4 narrow length", g, GL / 2);
        check_words(0, 1'b0, "R4 narrow words");
        chk(cur[0] != prev0, "R13 differing runs", cur[0], ~prev0);
        prev0 = cur[0];

        // random mode runs
        for (int it = 0; it < 6; it++) begin
            wide = 1'($urandom % 2);
            run_rand(0, wide, g, rs);
            chk(g == exp_len(wide), wide ? "R3 length" : "R4 length", g, exp_len(wide));
            check_words(0, wide, wide ? "R3 words" : "R4 words");
            chk(cur[0] != prev0, "R13 differing runs", cur[0], ~prev0);
            prev0 = cur[0];
        end

        // R6 seed command
        wr(0, ISTAT, 32'h3);
        wr(0, CTRL, 32'd2);
        cnt = 0;
        rd(0, STAT, s);
        while (s[31] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            rd(0, STAT, s);
        end
        chk(cnt == SL, "R6 seed length", cnt, SL);
        rd(0, ISTAT, s); chk(s == 32'h2, "R6 seed-done", s, 32'h2);

        // R8 ignored commands while idle
        rd(0, W0, prev0);
        wr(0, CTRL, 32'd3);
        wr(0, CTRL, 32'd0);
        repeat (2) @(negedge clk);
        rd(0, STAT, s); chk(s == 32'h200, "R8 idle codes 0/3", s, 32'h200);
        rd(0, W0, s); chk(s == prev0, "R8 words kept", s, prev0);
        // R8 commands while busy
        wr(0, MODE, 32'h8);
        wr(0, CTRL, 32'd1);
        wr(0, CTRL, 32'd2);
        wr(0, CTRL, 32'd1);
        cnt = 0; rs = 1'b0;
        rd(0, STAT, s);
        while (s[30] && cnt < 1000) begin
            cnt++;
            if (s[31]) rs = 1'b1;
            @(negedge clk);
            rd(0, STAT, s);
        end
        chk(cnt == GL - 4, "R8 busy length kept", cnt, GL - 4);
        chk(!rs && !s[31], "R8 no seed from busy write", {31'd0, rs | s[31]}, 0);

        // R11 auto reseed
        wr(0, LIM, 32'd3);
        wr(0, CTRL, 32'd2);
        wait_idle(0);
        run_rand(0, 1'b1, g, rs); chk(!rs, "R11 wide 2<3", rs, 0); wait_idle(0);
        run_rand(0, 1'b1, g, rs); chk(rs,  "R11 wide 4>=3", rs, 1); wait_idle(0);
        run_rand(0, 1'b0, g, rs); chk(!rs, "R11 narrow 1", rs, 0); wait_idle(0);
        run_rand(0, 1'b0, g, rs); chk(!rs, "R11 narrow 2", rs, 0); wait_idle(0);
        run_rand(0, 1'b0, g, rs); chk(rs,  "R11 narrow 3", rs, 1); wait_idle(0);
        wr(0, LIM, 32'd0);
        run_rand(0, 1'b1, g, rs); chk(!rs, "R11 off a", rs, 0); wait_idle(0);
        run_rand(0, 1'b1, g, rs); chk(!rs, "R11 off b", rs, 0); wait_idle(0);

        // R9 / R10 random flag and enable mixes
        wr(0, ISTAT, 32'h3);
        exp_is = 2'b00;
        for (int it = 0; it < 24; it++) begin
            if (exp_is == 2'b00) begin
                if ($urandom % 2 == 0) begin
                    run_rand(0, 1'b0, g, rs); wait_idle(0); exp_is = 2'b01;
                end else begin
                    wr(0, CTRL, 32'd2); wait_idle(0); exp_is = 2'b10;
                end
                if ($urandom % 2 == 0) begin
                    wr(0, CTRL, 32'd2); wait_idle(0); exp_is = exp_is | 2'b10;
                end
            end
            ie  = 3'($urandom);
            clr = 2'($urandom);
            wr(0, IE, {ie[2], 29'd0, ie[1:0]});
            #0.1;
            chk(irq0 == exp_irq(ie, exp_is), "R10 irq", irq0, exp_irq(ie, exp_is));
            wr(0, ISTAT, {30'd0, clr});
            exp_is = exp_is & ~clr;
            rd(0, ISTAT, s);
            chk(s[1:0] == exp_is, "R9 w1c", s, exp_is);
            chk(irq0 == exp_irq(ie, exp_is), "R10 irq after clear", irq0, exp_irq(ie, exp_is));
        end

        // R7 unseeded generate on second copy
        wr(1, CTRL, 32'd1);
        cnt = 0;
        rd(1, STAT, s);
        while (s[31] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            rd(1, STAT, s);
        end
        chk(cnt == SL, "R7 seed before gen", cnt, SL);
        cnt = 0;
        while (s[30] && cnt < 1000) begin
            cnt++;
            @(negedge clk);
            rd(1, STAT, s);
        end
        chk(cnt == GL / 2, "R7 gen after seed", cnt, GL / 2);
        chk(s == 32'h200, "R7 seeded", s, 32'h200);
        rd(1, ISTAT, s); chk(s == 32'h3, "R7 flags", s, 32'h3);
        check_words(1, 1'b0, "R7 words");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule